// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Configurable Character Format

This block sends and receives characters over a two-wire asynchronous serial line. Transmitter and receiver share one character format. The format is chosen by a set of static configuration pins: 7 or 8 data bits, an optional even or odd parity bit, an optional address/data flag bit for multi-drop links, and 1 or 2 stop bits. Bits go out and come in least significant bit first. Each bit lasts 16 ticks of a shared 16x sampling clock.

The sampling tick comes from one of two sources. One is an internal programmable divider on the system clock. The other is an external clock input running at 16 times the bit rate; when it is selected, the divider plays no part. With the internal source the block can also drive a serial clock output at the bit rate.

Characters to send enter on a valid/ready stream. The transmitter accepts one character only when it is idle, so `tx_ready` low is back-pressure that lasts a whole frame. Received characters leave on a valid/ready stream with a one-entry holding stage. If the consumer holds `rx_ready` low while a newer character completes, the newer one is dropped and an overrun is flagged. The receiver also flags framing errors, parity errors and line breaks through sticky flags, which are cleared with write-one-to-clear pulses.

Top module: `sio_async_xcvr`

## Requirements
- R1: `tx_ready` is high exactly when the transmitter is idle, and `txd` is high while idle. When `tx_valid && tx_ready` is sampled at a clock edge, the character is sent as a frame: first a low start bit, then the data bits LSB first. Each bit lasts 16 sampling ticks.
- R2: The frame after the start bit is laid out as follows:
  - 7 data bits (`cfg_data8`=0) or 8 data bits (`cfg_data8`=1);
  - then, if `cfg_par_en`=1, a parity bit, equal to the XOR of the data bits, inverted when `cfg_par_odd`=1;
  - then, if `cfg_mp_en`=1, the flag bit (`tx_mpb` / `rx_mpb`);
  - then 1 high stop bit, or 2 when `cfg_stop2`=1.
- R3: Clock source encoding for `cfg_clk_sel`:
  - 00: internal source, no clock output;
  - 01: internal source with a clock output;
  - 1x: external source.

  With the internal source, one tick occurs every `cfg_baud_div`+1 system clocks. With 01, `sclk_out` has a period of 16 ticks and is high for 8 of them; in every other setting it stays low.
- R4: With `cfg_clk_sel`[1]=1, one tick occurs for each rising edge of `ext_clk16`, taken through a 2-flop synchronizer. `cfg_baud_div` has no effect.
- R5: The receiver arms only after it has seen `rxd` high, and starts on a low level at a tick. It confirms the start bit at the 8th tick. If `rxd` is high there, it drops back to idle with no character. Otherwise each further bit is sampled 16 ticks after the previous one. The character is delivered on `rx_data`/`rx_mpb` with `rx_valid`; in 7-bit mode `rx_data[7]` is 0.
- R6: While `rx_valid` is high and `rx_ready` is low, `rx_valid`, `rx_data` and `rx_mpb` hold their values.
- R7: A low sample in any stop bit sets `err_frame`. The character is still delivered.
- R8: A received parity bit that differs from the one R2 defines sets `err_parity`. The character is still delivered.
- R9: If a character completes while `rx_valid` is high and `rx_ready` is low, `err_overrun` is set, the new character is dropped and the held one is kept.
- R10: A frame whose every sample (start through last stop) is low sets `brk_det` and `err_frame`, and no character is delivered.
- R11: The flags are sticky. Writing 1 to `flag_clr` bit 0/1/2/3 clears `err_frame`/`err_parity`/`err_overrun`/`brk_det` respectively. If a new event arrives in the same cycle, the flag stays set.
- R12: After reset: `txd`=1, `tx_ready`=1, `rx_valid`=0, all flags 0, `sclk_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_data8 | input | 1 | 1: 8 data bits, 0: 7 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | Odd parity when 1 |
| cfg_mp_en | input | 1 | Address/data flag bit present |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| cfg_clk_sel | input | 2 | Tick source and clock output select |
| cfg_baud_div | input | DIV_W | Internal divider: tick every value+1 clocks |
| ext_clk16 | input | 1 | External 16x bit-rate clock |
| sclk_out | output | 1 | Bit-rate clock output |
| tx_valid | input | 1 | Transmit character offered |
| tx_ready | output | 1 | Transmitter idle, accepts a character |
| tx_data | input | 8 | Transmit data |
| tx_mpb | input | 1 | Transmit flag bit |
| txd | output | 1 | Serial output line |
| rxd | input | 1 | Serial input line |
| rx_valid | output | 1 | Received character held |
| rx_ready | input | 1 | Consumer takes the held character |
| rx_data | output | 8 | Received data |
| rx_mpb | output | 1 | Received flag bit |
| err_frame | output | 1 | Sticky framing error |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun error |
| brk_det | output | 1 | Sticky break detected |
| flag_clr | input | 4 | Write-one-to-clear pulses for the four flags |

## Verification
The assertions take for granted that the configuration pins stay constant during any frame, in either direction. They also assume `flag_clr` is a short pulse, not a level held across error events. The stimulus changes the format and clock source only after both directions have gone idle and the line has been high for a full bit. It drives `rxd` with whole bit times derived from the chosen tick period, and it pulses `flag_clr` for a single cycle.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int FRM_MAX = 13;

  typedef struct packed {
    logic data8;
    logic par_en;
    logic par_odd;
    logic mp_en;
    logic stop2;
  } fmt_t;

  typedef struct packed {
    logic [7:0] data;
    logic       mpb;
    logic       par_bad;
    logic       stop_bad;
    logic       all_low;
  } rx_res_t;

  function automatic logic [3:0] frame_len(fmt_t f);
    return 4'd1 + (f.data8 ? 4'd8 : 4'd7) + {3'b000, f.par_en} +
           {3'b000, f.mp_en} + (f.stop2 ? 4'd2 : 4'd1);
  endfunction

  function automatic logic par_bit(fmt_t f, logic [7:0] d);
    logic p;
    p = f.data8 ? ^d : ^d[6:0];
    return p ^ f.par_odd;
  endfunction

  function automatic logic [FRM_MAX-1:0] build_frame(fmt_t f, logic [7:0] d, logic mpb);
    logic [FRM_MAX-1:0] fr;
    logic [3:0]         pos;
    fr    = '1;
    fr[0] = 1'b0;
    for (int i = 0; i < 8; i++)
      if (i < 7 || f.data8) fr[1+i] = d[i];
    pos = f.data8 ? 4'd9 : 4'd8;
    if (f.par_en) begin
      fr[pos] = par_bit(f, d);
      pos     = pos + 4'd1;
    end
    if (f.mp_en) fr[pos] = mpb;
    return fr;
  endfunction

  function automatic rx_res_t decode(fmt_t f, logic [FRM_MAX-1:0] s);
    rx_res_t    r;
    logic [3:0] pos;
    logic [3:0] len;
    logic       any_high;
    r.data = s[8:1];
    if (!f.data8) r.data[7] = 1'b0;
    pos       = f.data8 ? 4'd9 : 4'd8;
    r.par_bad = 1'b0;
    if (f.par_en) begin
      r.par_bad = (s[pos] != par_bit(f, r.data));
      pos       = pos + 4'd1;
    end
    r.mpb = 1'b0;
    if (f.mp_en) begin
      r.mpb = s[pos];
      pos   = pos + 4'd1;
    end
    r.stop_bad = !s[pos];
    if (f.stop2 && !s[pos + 4'd1]) r.stop_bad = 1'b1;
    len      = frame_len(f);
    any_high = 1'b0;
    for (int i = 0; i < FRM_MAX; i++)
      if (i < int'(len) && s[i]) any_high = 1'b1;
    r.all_low = !any_high;
    return r;
  endfunction

endpackage

// File: rtl/sio_baud.sv
module sio_baud #(
  parameter int DIV_W    = 12,
  parameter int EXT_SYNC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_ext,
  input  logic             clk_out_en,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_clk,
  output logic             tick,
  output logic             sclk
);

  logic [EXT_SYNC:0] ext_sh;
  logic [DIV_W-1:0]  cnt;
  logic [3:0]        ph16;
  logic              int_tick;
  logic              ext_rise;

  assign int_tick = !sel_ext && (cnt >= div);
  assign ext_rise = ext_sh[EXT_SYNC-1] && !ext_sh[EXT_SYNC];
  assign tick     = sel_ext ? ext_rise : int_tick;
  assign sclk     = clk_out_en && !sel_ext && ph16[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sh <= '0;
      cnt    <= '0;
      ph16   <= '0;
    end else begin
      ext_sh <= {ext_sh[EXT_SYNC-1:0], ext_clk};
      if (sel_ext || int_tick) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
      if (tick) ph16 <= ph16 + 4'd1;
    end
  end

endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  fmt_t       fmt,
  input  logic       tick,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_mpb,
  output logic       txd
);

  logic               busy;
  logic [FRM_MAX-1:0] sh;
  logic [3:0]         left;
  logic [3:0]         ph;

  assign in_ready = !busy;
  assign txd      = busy ? sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      ph   <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        sh   <= build_frame(fmt, in_data, in_mpb);
        left <= frame_len(fmt) - 4'd1;
        ph   <= '0;
        busy <= 1'b1;
      end
    end else if (tick) begin
      if (ph == 4'd15) begin
        ph <= '0;
        if (left == 4'd0) begin
          busy <= 1'b0;
        end else begin
          sh   <= {1'b1, sh[FRM_MAX-1:1]};
          left <= left - 4'd1;
        end
      end else begin
        ph <= ph + 4'd1;
      end
    end
  end

endmodule

// File: rtl/sio_rx.sv
module sio_rx
  import sio_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  fmt_t    fmt,
  input  logic    tick,
  input  logic    rxd,
  output logic    fin,
  output rx_res_t res
);

  logic               r1, r2;
  logic               armed;
  logic               active;
  logic [3:0]         ph;
  logic [3:0]         idx;
  logic [FRM_MAX-1:0] samp;

  assign res = decode(fmt, samp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1     <= 1'b1;
      r2     <= 1'b1;
      armed  <= 1'b0;
      active <= 1'b0;
      ph     <= '0;
      idx    <= '0;
      samp   <= '1;
      fin    <= 1'b0;
    end else begin
      r1  <= rxd;
      r2  <= r1;
      fin <= 1'b0;
      if (!active) begin
        if (r2) armed <= 1'b1;
        if (tick && armed && !r2) begin
          active <= 1'b1;
          armed  <= 1'b0;
          ph     <= 4'd1;
          idx    <= '0;
        end
      end else if (tick) begin
        ph <= ph + 4'd1;
        if (ph == 4'd7) begin
          if (idx == 4'd0 && r2) begin
            active <= 1'b0;
          end else begin
            samp[idx] <= r2;
            if (idx == frame_len(fmt) - 4'd1) begin
              active <= 1'b0;
              fin    <= 1'b1;
            end else begin
              idx <= idx + 4'd1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/sio_async_xcvr.sv
module sio_async_xcvr
  import sio_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_data8,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_mp_en,
  input  logic             cfg_stop2,
  input  logic [1:0]       cfg_clk_sel,
  input  logic [DIV_W-1:0] cfg_baud_div,
  input  logic             ext_clk16,
  output logic             sclk_out,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  input  logic             tx_mpb,
  output logic             txd,
  input  logic             rxd,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_mpb,
  output logic             err_frame,
  output logic             err_parity,
  output logic             err_overrun,
  output logic             brk_det,
  input  logic [3:0]       flag_clr
);

  fmt_t    fmt;
  logic    tick;
  logic    fin;
  rx_res_t res;
  logic    hold_v;
  logic [7:0] hold_d;
  logic    hold_m;
  logic [3:0] flags;
  logic [3:0] set_v;
  logic    take;
  logic    good;

  assign fmt = '{data8: cfg_data8, par_en: cfg_par_en, par_odd: cfg_par_odd,
                 mp_en: cfg_mp_en, stop2: cfg_stop2};

  sio_baud #(.DIV_W(DIV_W), .EXT_SYNC(2)) u_baud (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_ext    (cfg_clk_sel[1]),
    .clk_out_en (cfg_clk_sel == 2'b01),
    .div        (cfg_baud_div),
    .ext_clk    (ext_clk16),
    .tick       (tick),
    .sclk       (sclk_out)
  );

  sio_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .fmt      (fmt),
    .tick     (tick),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_data  (tx_data),
    .in_mpb   (tx_mpb),
    .txd      (txd)
  );

  sio_rx u_rx (
    .clk   (clk),
    .rst_n (rst_n),
    .fmt   (fmt),
    .tick  (tick),
    .rxd   (rxd),
    .fin   (fin),
    .res   (res)
  );

  assign take = hold_v && rx_ready;
  assign good = fin && !res.all_low;

  // flag order: 0 framing, 1 parity, 2 overrun, 3 break
  assign set_v[0] = fin && res.stop_bad;
  assign set_v[1] = good && res.par_bad;
  assign set_v[2] = good && hold_v && !rx_ready;
  assign set_v[3] = fin && res.all_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_d <= '0;
      hold_m <= 1'b0;
      flags  <= '0;
    end else begin
      if (take) hold_v <= 1'b0;
      if (good && !(hold_v && !rx_ready)) begin
        hold_v <= 1'b1;
        hold_d <= res.data;
        hold_m <= res.mpb;
      end
      flags <= (flags & ~flag_clr) | set_v;
    end
  end

  assign rx_valid    = hold_v;
  assign rx_data     = hold_d;
  assign rx_mpb      = hold_m;
  assign err_frame   = flags[0];
  assign err_parity  = flags[1];
  assign err_overrun = flags[2];
  assign brk_det     = flags[3];

endmodule

// File: rtl/sio_async_xcvr_chk.sv
module sio_async_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_clk_sel,
  input logic       sclk_out,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       txd,
  input logic       rx_valid,
  input logic       rx_ready,
  input logic [7:0] rx_data,
  input logic       rx_mpb,
  input logic       err_frame,
  input logic       err_parity,
  input logic       err_overrun,
  input logic       brk_det,
  input logic [3:0] flag_clr
);

  p_idle_line_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> txd);

  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready && !txd);

  p_sclk_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_sel != 2'b01 |-> !sclk_out);

  p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data) && $stable(rx_mpb));

  p_overrun_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_overrun && !flag_clr[2] |=> err_overrun);

  p_parity_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity && !flag_clr[1] |=> err_parity);

  p_break_frames_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_det) |-> err_frame);

endmodule

bind sio_async_xcvr sio_async_xcvr_chk u_chk (.*);

// File: tb/sim_sio_async_xcvr.sv
`timescale 1ns/1ps
module sim_sio_async_xcvr;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c8 = 1'b1, cpar = 1'b0, codd = 1'b0, cmp = 1'b0, cst2 = 1'b0;
  logic [1:0]  csel = 2'b01;
  logic [11:0] cdiv = 12'd3;
  logic ext = 1'b0;
  logic ext_on = 1'b0;
  logic sclk_out;
  logic tx_valid = 1'b0, tx_ready, tx_mpb = 1'b0, txd;
  logic [7:0] tx_data = '0;
  logic rxd = 1'b1;
  logic rx_valid, rx_ready = 1'b1, rx_mpb;
  logic [7:0] rx_data;
  logic err_frame, err_parity, err_overrun, brk_det;
  logic [3:0] flag_clr = '0;

  int n_vec = 0;
  int n_bad = 0;
  int bit_clks = 64;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  initial forever begin
    #15;
    ext = ext_on ? ~ext : 1'b0;
  end

  sio_async_xcvr #(.DIV_W(12)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_data8(c8), .cfg_par_en(cpar), .cfg_par_odd(codd), .cfg_mp_en(cmp),
    .cfg_stop2(cst2), .cfg_clk_sel(csel), .cfg_baud_div(cdiv),
    .ext_clk16(ext), .sclk_out(sclk_out),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_mpb(tx_mpb),
    .txd(txd), .rxd(rxd),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_mpb(rx_mpb),
    .err_frame(err_frame), .err_parity(err_parity), .err_overrun(err_overrun),
    .brk_det(brk_det), .flag_clr(flag_clr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference frame from the format rules
  task automatic mk(input logic [7:0] d, input logic mp, output logic [12:0] b, output int n);
    b = '1;
    n = 0;
    b[n] = 1'b0; n++;
    for (int i = 0; i < (c8 ? 8 : 7); i++) begin b[n] = d[i]; n++; end
    if (cpar) begin b[n] = (c8 ? ^d : ^d[6:0]) ^ codd; n++; end
    if (cmp) begin b[n] = mp; n++; end
    b[n] = 1'b1; n++;
    if (cst2) begin b[n] = 1'b1; n++; end
  endtask

  task automatic wait_clks(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic tx_check(input logic [7:0] d, input logic mp, input string tag);
    logic [12:0] b, got;
    int n;
    mk(d, mp, b, n);
    got = '1;
    @(negedge clk);
    tx_data = d; tx_mpb = mp; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    wait_clks(bit_clks / 2 - 1);
    for (int i = 0; i < n; i++) begin
      got[i] = txd;
      if (i < n - 1) wait_clks(bit_clks);
    end
    chk(got == b, tag, {19'b0, got}, {19'b0, b});
    wait_clks(bit_clks);
  endtask

  task automatic rx_drive(input logic [12:0] b, input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = b[i];
      wait_clks(bit_clks);
    end
    rxd = 1'b1;
    wait_clks(bit_clks);
  endtask

  task automatic rx_char(input logic [7:0] d, input logic mp);
    logic [12:0] b;
    int n;
    mk(d, mp, b, n);
    exp_q.push_back({mp, (c8 ? d : {1'b0, d[6:0]})});
    rx_drive(b, n);
  endtask

  task automatic clear(input logic [3:0] m);
    @(negedge clk);
    flag_clr = m;
    @(negedge clk);
    flag_clr = '0;
  endtask

  // monitor: pops the scoreboard on each transfer
  always @(negedge clk) begin
    if (rst_n && rx_valid && rx_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected char", {23'b0, rx_mpb, rx_data}, 32'h0);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        chk({rx_mpb, rx_data} == e, "R5 R2 rx char", {23'b0, rx_mpb, rx_data}, {23'b0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [12:0] b;
    int n, c;
    wait_clks(4);
    chk(txd === 1'b1 && tx_ready === 1'b1, "R12 tx reset", {30'b0, txd, tx_ready}, 3);
    chk(rx_valid === 1'b0 && {err_frame, err_parity, err_overrun, brk_det} === 4'b0 && sclk_out === 1'b0,
        "R12 rx/flags reset", {27'b0, rx_valid, err_frame, err_parity, err_overrun, brk_det}, 0);
    rst_n = 1'b1;
    wait_clks(4);

    // R3: clock output period 16 ticks, 50 percent
    @(posedge sclk_out);
    @(negedge clk);
    c = 0;
    while (sclk_out) begin @(negedge clk); c++; end
    chk(c == 32, "R3 sclk high width", c, 32);
    c = 0;
    while (!sclk_out) begin @(negedge clk); c++; end
    chk(c == 32, "R3 sclk low width", c, 32);

    // R1: 8N1 transmit
    tx_check(8'hA5, 1'b0, "R1 tx 8N1");
    // R2: 7 data, even parity, flag bit, 2 stops
    c8 = 0; cpar = 1; cmp = 1; cst2 = 1;
    tx_check(8'h3C, 1'b1, "R2 tx 7E+mp+2");
    codd = 1;
    tx_check(8'h13, 1'b0, "R2 tx 7O+mp+2");

    // R5, R2: receive both formats
    rx_char(8'h41, 1'b1);
    c8 = 1; cpar = 0; codd = 0; cmp = 0; cst2 = 0;
    rx_char(8'h5A, 1'b0);
    rx_char(8'hFF, 1'b0);
    wait_clks(10);
    chk({err_frame, err_parity, err_overrun, brk_det} == 0, "R5 clean rx no flags",
        {28'b0, err_frame, err_parity, err_overrun, brk_det}, 0);

    // R8: odd parity, wrong parity bit
    cpar = 1; codd = 1;
    mk(8'h6E, 1'b0, b, n);
    b[9] = ~b[9];
    exp_q.push_back({1'b0, 8'h6E});
    rx_drive(b, n);
    wait_clks(10);
    chk(err_parity === 1'b1 && err_frame === 1'b0, "R8 parity error", {30'b0, err_parity, err_frame}, 2);
    wait_clks(200);
    chk(err_parity === 1'b1, "R11 parity sticky", err_parity, 1);
    clear(4'b0010);
    chk(err_parity === 1'b0, "R11 parity cleared", err_parity, 0);

    // R7: stop bit sampled low
    cpar = 0; codd = 0;
    mk(8'h33, 1'b0, b, n);
    b[9] = 1'b0;
    exp_q.push_back({1'b0, 8'h33});
    rx_drive(b, n);
    wait_clks(10);
    chk(err_frame === 1'b1 && brk_det === 1'b0, "R7 framing error", {30'b0, err_frame, brk_det}, 2);
    clear(4'b0001);
    chk(err_frame === 1'b0, "R11 frame cleared", err_frame, 0);

    // R9, R6: overrun keeps the held character
    rx_ready = 1'b0;
    rx_char(8'h11, 1'b0);
    mk(8'h22, 1'b0, b, n);
    rx_drive(b, n);
    wait_clks(10);
    chk(err_overrun === 1'b1, "R9 overrun flag", err_overrun, 1);
    chk(rx_valid === 1'b1 && rx_data === 8'h11, "R9 R6 old char kept", {23'b0, rx_valid, rx_data}, 32'h111);
    rx_ready = 1'b1;
    wait_clks(5);
    chk(rx_valid === 1'b0, "R6 released on ready", rx_valid, 0);
    clear(4'b0100);

    // R10: break
    rx_drive(13'b0, 10);
    wait_clks(10);
    chk(brk_det === 1'b1 && err_frame === 1'b1, "R10 break flags", {30'b0, brk_det, err_frame}, 3);
    chk(rx_valid === 1'b0, "R10 no char on break", rx_valid, 0);
    clear(4'b1001);
    chk({brk_det, err_frame} === 2'b0, "R11 break cleared", {30'b0, brk_det, err_frame}, 0);

    // R5: short glitch is rejected
    @(negedge clk);
    rxd = 1'b0;
    wait_clks(10);
    rxd = 1'b1;
    wait_clks(bit_clks * 12);
    chk(rx_valid === 1'b0 && err_frame === 1'b0, "R5 glitch ignored", {30'b0, rx_valid, err_frame}, 0);

    // R4: external 16x clock, divider value irrelevant
    ext_on = 1'b1;
    csel = 2'b10;
    cdiv = 12'd1;
    bit_clks = 96;
    wait_clks(bit_clks);
    chk(sclk_out === 1'b0, "R3 no sclk in external mode", sclk_out, 0);
    rx_char(8'hC3, 1'b0);
    tx_check(8'h96, 1'b0, "R4 tx external clock");
    wait_clks(20);
    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule